// File: doc/BRIEF.md
# Switching Activity Load Generator

This block is a deliberate worst-case load for a chip's power delivery network. It holds a matrix of registers that all flip together, so the dynamic current can be stepped between an idle level and a full-switching level. One central toggle register feeds a small buffer register for each row, and each buffer drives every register in its row. This keeps the fanout of each net low enough for full clock speed. Every matrix bit feeds one wide OR, and the OR drives a single observation output, so synthesis cannot remove the matrix.

A 2-bit mode input chooses the load level. The first level holds every register, so only the clock tree is active. The second level switches the matrix on every clock. The third level keys the switching on and off with a free-running counter. The counter's top bit is driven out so that a scope can trigger on the start of each burst. The current step at that edge shows the step response of the supply.

Top module: `toggle_stress_top`

## Requirements
- R1: A synchronous active-high reset clears the counter, the mode register, the toggle register, every row buffer and every matrix bit. While reset is held and on the first cycle after it, `obs_or` and `burst_mon` are 0.
- R2: In modes 2'b00 and 2'b01 the toggle register holds its value, so `obs_or` stays constant once the pipeline has drained.
- R3: In mode 2'b10 the toggle register inverts on every clock, so `obs_or` alternates on every cycle.
- R4: In mode 2'b11 the toggle register inverts on every clock while the counter's top bit is 1. It holds while that bit is 0.
- R5: The counter is CNT_W bits wide. It increments on every clock after reset and wraps at 2^CNT_W. `burst_mon` is its top bit, which gives a 50% duty square wave with a period of 2^CNT_W clocks.
- R6: The mode input is registered once before use. A mode change applied before clock edge k first affects the toggle register at edge k+1, and first affects `obs_or` at edge k+3.
- R7: Each row buffer copies the toggle register, and each matrix bit copies its row buffer. Every matrix bit therefore equals the toggle value from two clocks earlier, and `obs_or` is the OR of all ROWS*COLS matrix bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Load mode: 00/01 hold, 10 continuous, 11 burst |
| obs_or | output | 1 | OR of every matrix bit |
| burst_mon | output | 1 | Counter top bit, used as the burst trigger |

## Verification
The bench builds the block with ROWS=3, COLS=5 and CNT_W=4. At these values a full burst period takes only 16 clocks, so counter wraps and several burst on/off edges fall inside short mode segments. The segments include burst mode entered in both counter phases and mode changes that land mid-burst. The small matrix still has several rows, so each row buffer and the wide OR are still exercised.

// File: rtl/stress_pkg.sv
package stress_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD_A = 2'b00,
        MODE_HOLD_B = 2'b01,
        MODE_RUN    = 2'b10,
        MODE_BURST  = 2'b11
    } load_mode_e;

    function automatic logic mode_switches(input load_mode_e m, input logic phase);
        return (m == MODE_RUN) || ((m == MODE_BURST) && phase);
    endfunction

endpackage

// File: rtl/stress_timer.sv
module stress_timer
    import stress_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_in,
    output load_mode_e mode_q_o,
    output logic       phase_o
);

    localparam int MSB = CNT_W - 1;

    typedef struct packed {
        load_mode_e       mode;
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mode = load_mode_e'(mode_in);
        st_d.cnt  = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{mode: MODE_HOLD_A, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q_o = st_q.mode;
    assign phase_o  = st_q.cnt[MSB];

    logic run_seen_q;
    always_ff @(posedge clk) begin
        if (rst) run_seen_q <= 1'b0;
        else     run_seen_q <= 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        run_seen_q |-> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R5

    AST_MODE_LAG: assert property (@(posedge clk) disable iff (rst)
        run_seen_q |-> (st_q.mode == load_mode_e'($past(mode_in)))); // R6

endmodule

// File: rtl/stress_toggle.sv
module stress_toggle
    import stress_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  load_mode_e mode,
    input  logic       phase,
    output logic       tog_o
);

    typedef struct packed {
        logic tog;
    } tog_state_t;

    tog_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_switches(mode, phase)) begin
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{tog: 1'b0};
        else     st_q <= st_d;
    end

    assign tog_o = st_q.tog;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD_A || mode == MODE_HOLD_B) |=> $stable(st_q.tog)); // R2

    AST_RUN_FLIP: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN) |=> (st_q.tog != $past(st_q.tog))); // R3

    AST_BURST_GATE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BURST && !phase) |=> $stable(st_q.tog)); // R4

endmodule

// File: rtl/stress_row.sv
module stress_row #(
    parameter int COLS = 50
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tog_in,
    output logic [COLS-1:0] bits_o
);

    typedef struct packed {
        logic            drv;
        logic [COLS-1:0] cells;
    } row_state_t;

    row_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.drv   = tog_in;
        st_d.cells = {COLS{st_q.drv}};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bits_o = st_q.cells;

    AST_ROW_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (st_q.cells == '0) || (st_q.cells == '1)); // R7

endmodule

// File: rtl/toggle_stress_top.sv
module toggle_stress_top
    import stress_pkg::*;
#(
    parameter int ROWS  = 30,
    parameter int COLS  = 50,
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    output logic       obs_or,
    output logic       burst_mon
);

    localparam int CELLS = ROWS * COLS;

    load_mode_e      mode_q;
    logic            phase;
    logic            tog;
    logic [CELLS-1:0] all_bits;

    stress_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (mode_sel),
        .mode_q_o (mode_q),
        .phase_o  (phase)
    );

    stress_toggle u_toggle (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode_q),
        .phase (phase),
        .tog_o (tog)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        stress_row #(.COLS(COLS)) u_row (
            .clk    (clk),
            .rst    (rst),
            .tog_in (tog),
            .bits_o (all_bits[r*COLS +: COLS])
        );
    end

    assign obs_or    = |all_bits;
    assign burst_mon = phase;

    logic [1:0] settle_q;
    always_ff @(posedge clk) begin
        if (rst)                settle_q <= 2'd0;
        else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
    end

    AST_OBS_LAG: assert property (@(posedge clk) disable iff (rst)
        (settle_q == 2'd2) |-> (obs_or == $past(tog, 2))); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!obs_or && !burst_mon)); // R1

endmodule

// File: tb/tb_toggle_stress_top.sv
module tb_toggle_stress_top;

    localparam int ROWS  = 3;
    localparam int COLS  = 5;
    localparam int CNT_W = 4;
    localparam int SEGS  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       obs_or, burst_mon;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    toggle_stress_top #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .obs_or(obs_or), .burst_mon(burst_mon)
    );

    // Reference model written from the requirements
    logic [1:0]       m_mode;
    logic [CNT_W-1:0] m_cnt;
    logic             m_tog, m_buf, m_arr;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_mode <= 2'b00; m_cnt <= '0; m_tog <= 1'b0; m_buf <= 1'b0; m_arr <= 1'b0;
        end else begin
            m_mode <= mode_sel;
            m_cnt  <= m_cnt + 1'b1;
            if (m_mode == 2'b10 || (m_mode == 2'b11 && m_cnt[CNT_W-1])) m_tog <= ~m_tog;
            m_buf  <= m_tog;
            m_arr  <= m_buf;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    task automatic step(input logic [1:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R7 obs_or", obs_or, m_arr);
            check("R5 burst_mon", burst_mon, m_cnt[CNT_W-1]);
            mode_sel = m;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mode_sel = 2'b00;
        repeat (2) @(negedge clk);
        check("R1 obs_or in reset", obs_or, 1'b0);
        check("R1 burst_mon in reset", burst_mon, 1'b0);
    endtask

    // mode, cycles
    localparam logic [1:0] SEG_MODE [SEGS] = '{2'b10, 2'b00, 2'b11, 2'b01, 2'b10, 2'b11, 2'b10, 2'b00};
    localparam int         SEG_LEN  [SEGS] = '{7, 5, 40, 6, 3, 21, 9, 4};

    initial begin : watchdog
        wait (cycles > 50000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic held;
        // R1: reset state
        do_reset();
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 obs_or after reset", obs_or, 1'b0);
        check("R1 burst_mon after reset", burst_mon, 1'b0);

        // Vector table walk: R2 R3 R4 R5 R7 against the model
        for (int s = 0; s < SEGS; s++) step(SEG_MODE[s], SEG_LEN[s]);
        step(2'b00, 4);

        // R6: latency of a mode change from reset state
        do_reset();
        mode_sel = 2'b10;
        rst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 obs_or before edge k+3", obs_or, 1'b0);
        @(negedge clk);
        check("R6 obs_or at edge k+3", obs_or, 1'b1);
        @(negedge clk);
        check("R3 obs_or alternates", obs_or, 1'b0);
        @(negedge clk);
        check("R3 obs_or alternates", obs_or, 1'b1);

        // R2: mode 01 leaves the matrix untouched
        mode_sel = 2'b01;
        repeat (4) @(negedge clk);
        held = obs_or;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R2 mode 01 holds obs_or", obs_or, held);
        end

        // R5: counter wraps, burst_mon period 2^CNT_W with 50% duty
        do_reset();
        rst = 1'b0;
        for (int i = 1; i <= 2 * (1 << CNT_W); i++) begin
            @(negedge clk);
            check("R5 burst_mon phase", burst_mon, ((i % (1 << CNT_W)) >= (1 << (CNT_W - 1))) ? 1'b1 : 1'b0);
        end

        // R4: burst mode does nothing while the counter top bit is 0
        do_reset();
        mode_sel = 2'b11;
        rst = 1'b0;
        for (int i = 1; i <= (1 << (CNT_W - 1)) + 2; i++) begin
            @(negedge clk);
            check("R4 burst low phase holds", obs_or, 1'b0);
        end
        step(2'b11, 20);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule